// File: doc/BRIEF.md
# Clock-Divider Configuration Loader

This block holds the six divider settings that feed a chip's clock generators: a general-purpose timer divide, a primary and a secondary VCO/auxiliary divide, a reference divide, a PLL divide, and a converter-clock divide. Software writes these values one word at a time to a single programming address. The block places each word into the next staging slot in a fixed order. A ready flag, which software can read at a status address, paces the writes.

Staged values do not reach the outputs at once. The timer divide and the primary VCO/auxiliary divide form a pair. Both go live together at the moment the second word of the pair is accepted. The other four dividers go live only when the operating mode moves into receive or transmit. Until a divider is first committed, its output follows one of two built-in default sets, chosen by a clock-select input pin. This means a part running from one of the two standard input frequencies needs no programming. Any other frequency must be programmed right after power-up.

Top module: `clkcfg_loader`

## Requirements
- R1: After reset, `prg_ready` is 1. With `clk_sel`=0 the outputs are timer 0x017, VCO-A 0x085, ref 0x024, PLL 0x1E0, VCO-B 0x140, conv 0x008. With `clk_sel`=1 they are 0x018, 0x088, 0x040, 0x200, 0x140, 0x008.
- R2: When `rd_addr` is 0xC6, `rd_data` bit 0 equals `prg_ready` and all other bits are 0. For any other `rd_addr`, `rd_data` is 0.
- R3: A write is accepted when `wr_en` is 1, `wr_addr` is 0xC8 and `prg_ready` is 1. After an accepted write, `prg_ready` is 0 for exactly `BUSY_CYC` (default 4) cycles and then returns to 1.
- R4: A write to 0xC8 while `prg_ready` is 0 is discarded. It stages nothing and does not advance the slot order.
- R5: Accepted words fill the slots in this order: timer, VCO-A, ref, PLL, VCO-B, conv. After conv, the next word goes to timer again. Reset returns the order to timer.
- R6: Only `wr_data[9:0]` is stored. The upper bits have no effect on any divider output.
- R7: When the VCO-A word is accepted, the timer and VCO-A outputs both take their staged values in the next cycle. Accepting the timer word alone changes no output.
- R8: The ref, PLL, VCO-B and conv outputs take their staged values in the cycle after `mode_in` changes to receive (01) or transmit (10). Only slots written since reset are affected. A change to idle (00) or reserved (11), or an unchanged mode, leaves these outputs unchanged.
- R9: A write with `wr_en` set to any address other than 0xC8 changes no divider, no slot order and no ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | Selects the default divider set |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data, low 10 bits used |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data (status) |
| mode_in | input | 2 | Operating mode: 00 idle, 01 receive, 10 transmit, 11 reserved |
| prg_ready | output | 1 | Programming-ready flag |
| div_timer | output | 10 | Active timer divide |
| div_vco_a | output | 10 | Active primary VCO/auxiliary divide |
| div_ref | output | 10 | Active reference divide |
| div_pll | output | 10 | Active PLL divide |
| div_vco_b | output | 10 | Active secondary VCO/auxiliary divide |
| div_conv | output | 10 | Active converter-clock divide |

## Verification
Faults in the slot counter do not show up at once. Each later word is steered into the wrong divider, but the error only appears at the next pair commit or the next mode change. For that reason the bench checks the outputs right after each commit event, using known word-to-slot positions, including after the order wraps. Errors in the busy counter appear within a few cycles as a wrong ready-low length. They also appear as a discarded write that was staged anyway, which becomes visible at the next mode commit.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned DIV_W   = 10;
  localparam int unsigned NUM_DIV = 6;
  localparam int unsigned IDX_W   = $clog2(NUM_DIV);

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_RX   = 2'b01,
    MODE_TX   = 2'b10,
    MODE_RSVD = 2'b11
  } op_mode_e;

  typedef logic [NUM_DIV-1:0][DIV_W-1:0] div_bank_t;

  // Built-in divider values for the two standard input frequencies.
  function automatic logic [DIV_W-1:0] dflt_div(input logic sel, input int unsigned idx);
    logic [DIV_W-1:0] v;
    case (idx)
      0:       v = sel ? 10'h018 : 10'h017;
      1:       v = sel ? 10'h088 : 10'h085;
      2:       v = sel ? 10'h040 : 10'h024;
      3:       v = sel ? 10'h200 : 10'h1E0;
      4:       v = 10'h140;
      default: v = 10'h008;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkcfg_gate.sv
module clkcfg_gate #(
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  output logic accept,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign ready  = (cnt_q == '0);
  assign accept = wr_hit & ready;

  always_comb begin
    cnt_en = accept | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (accept)            cnt_d = CNT_LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkcfg_stage.sv
module clkcfg_stage
  import clkcfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic [DIV_W-1:0]       word,
  output logic [IDX_W-1:0]       seq_idx,
  output div_bank_t              staged,
  output logic [NUM_DIV-1:0]     staged_vld,
  output logic                   pair_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIV - 1);
  localparam logic [IDX_W-1:0] PAIR_IDX = IDX_W'(1);

  logic [IDX_W-1:0] seq_q, seq_d;

  always_comb begin
    seq_d = seq_q;
    if (accept) seq_d = (seq_q == LAST_IDX) ? '0 : seq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_q <= '0;
    else if (accept) seq_q <= seq_d;
  end

  assign seq_idx   = seq_q;
  assign pair_done = accept && (seq_q == PAIR_IDX);

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_slot
    logic slot_ld;
    assign slot_ld = accept && (seq_q == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged[g]     <= '0;
        staged_vld[g] <= 1'b0;
      end else if (slot_ld) begin
        staged[g]     <= word;
        staged_vld[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkcfg_active.sv
module clkcfg_active
  import clkcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_sel,
  input  logic [1:0]         mode_in,
  input  div_bank_t          staged,
  input  logic [NUM_DIV-1:0] staged_vld,
  input  logic [DIV_W-1:0]   word,
  input  logic               pair_done,
  output logic               commit_mode,
  output div_bank_t          active
);
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_in;
  end

  assign commit_mode = (mode_in != mode_q) &&
                       ((mode_in == MODE_RX) || (mode_in == MODE_TX));

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    logic             ld;
    logic [DIV_W-1:0] ld_val;
    logic             ovr_q;
    logic [DIV_W-1:0] val_q;

    if (g < 2) begin : g_pair
      // Second word of the pair comes straight from the bus in its accept cycle.
      assign ld     = pair_done;
      assign ld_val = (g == 0) ? staged[0] : word;
    end else begin : g_mode
      assign ld     = commit_mode && staged_vld[g];
      assign ld_val = staged[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovr_q <= 1'b0;
        val_q <= '0;
      end else if (ld) begin
        ovr_q <= 1'b1;
        val_q <= ld_val;
      end
    end

    assign active[g] = ovr_q ? val_q : dflt_div(clk_sel, g);
  end
endmodule

// File: rtl/clkcfg_loader.sv
module clkcfg_loader
  import clkcfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BUSY_CYC  = 4,
  parameter logic [7:0]  PROG_ADDR = 8'hC8,
  parameter logic [7:0]  STAT_ADDR = 8'hC6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        mode_in,
  output logic              prg_ready,
  output logic [DIV_W-1:0]  div_timer,
  output logic [DIV_W-1:0]  div_vco_a,
  output logic [DIV_W-1:0]  div_ref,
  output logic [DIV_W-1:0]  div_pll,
  output logic [DIV_W-1:0]  div_vco_b,
  output logic [DIV_W-1:0]  div_conv
);
  logic               rst_sync_n;
  logic               wr_hit;
  logic               prog_accept;
  logic [IDX_W-1:0]   seq_idx;
  div_bank_t          staged;
  logic [NUM_DIV-1:0] staged_vld;
  logic               pair_done;
  logic               commit_mode;
  div_bank_t          active;
  logic [DIV_W-1:0]   word;
  logic               unused_hi_bits;

  assign word           = wr_data[DIV_W-1:0];
  assign unused_hi_bits = ^wr_data[DATA_W-1:DIV_W];
  assign wr_hit         = wr_en && (wr_addr == ADDR_W'(PROG_ADDR));

  clkcfg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkcfg_gate #(.BUSY_CYC(BUSY_CYC)) i_gate (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_hit (wr_hit),
    .accept (prog_accept),
    .ready  (prg_ready)
  );

  clkcfg_stage i_stage (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (prog_accept),
    .word       (word),
    .seq_idx    (seq_idx),
    .staged     (staged),
    .staged_vld (staged_vld),
    .pair_done  (pair_done)
  );

  clkcfg_active i_active (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clk_sel     (clk_sel),
    .mode_in     (mode_in),
    .staged      (staged),
    .staged_vld  (staged_vld),
    .word        (word),
    .pair_done   (pair_done),
    .commit_mode (commit_mode),
    .active      (active)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data[0] = prg_ready;
  end

  assign div_timer = active[0];
  assign div_vco_a = active[1];
  assign div_ref   = active[2];
  assign div_pll   = active[3];
  assign div_vco_b = active[4];
  assign div_conv  = active[5];
endmodule

// File: rtl/clkcfg_loader_chk.sv
module clkcfg_loader_chk
  import clkcfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUSY_CYC  = 4,
  parameter logic [7:0]  PROG_ADDR = 8'hC8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              prg_ready,
  input logic              prog_accept,
  input logic [IDX_W-1:0]  seq_idx,
  input logic              commit_mode,
  input logic [DIV_W-1:0]  div_timer,
  input logic [DIV_W-1:0]  div_vco_a,
  input logic [DIV_W-1:0]  div_ref,
  input logic [DIV_W-1:0]  div_pll,
  input logic [DIV_W-1:0]  div_vco_b,
  input logic [DIV_W-1:0]  div_conv
);
  localparam int unsigned LOW_W = $clog2(BUSY_CYC + 2);
  logic [LOW_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    low_cnt <= '0;
    else if (prg_ready) low_cnt <= '0;
    else                low_cnt <= low_cnt + 1'b1;
  end

  assert_accept_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_accept |=> !prg_ready);

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    low_cnt <= LOW_W'(BUSY_CYC));

  assert_discard_holds_index_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == ADDR_W'(PROG_ADDR) && !prg_ready) |=> (seq_idx == $past(seq_idx)));

  assert_index_range_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_idx < IDX_W'(NUM_DIV));

  assert_first_word_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_accept && seq_idx == '0) |=> ($stable(div_timer) && $stable(div_vco_a)));

  assert_group_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !commit_mode |=> ($stable(div_ref) && $stable(div_pll) && $stable(div_vco_b) && $stable(div_conv)));

  assert_foreign_addr_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr != ADDR_W'(PROG_ADDR)) |-> !prog_accept);
endmodule

bind clkcfg_loader clkcfg_loader_chk #(
  .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .PROG_ADDR(PROG_ADDR)
) i_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .prg_ready   (prg_ready),
  .prog_accept (prog_accept),
  .seq_idx     (seq_idx),
  .commit_mode (commit_mode),
  .div_timer   (div_timer),
  .div_vco_a   (div_vco_a),
  .div_ref     (div_ref),
  .div_pll     (div_pll),
  .div_vco_b   (div_vco_b),
  .div_conv    (div_conv)
);

// File: tb/test_clkcfg_loader.sv
`timescale 1ns/1ps
module test_clkcfg_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_sel;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  mode_in;
  logic        prg_ready;
  logic [9:0]  div_timer, div_vco_a, div_ref, div_pll, div_vco_b, div_conv;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  clkcfg_loader i_clkcfg_loader (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mode_in(mode_in), .prg_ready(prg_ready),
    .div_timer(div_timer), .div_vco_a(div_vco_a), .div_ref(div_ref),
    .div_pll(div_pll), .div_vco_b(div_vco_b), .div_conv(div_conv)
  );

  // Six words with junk in the upper bits (R6); slot order per R5.
  localparam logic [15:0] VEC_DATA [6] = '{16'hFC11, 16'hA322, 16'h5133, 16'h8244, 16'hF155, 16'h0266};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; clk_sel = sel; wr_en = 1'b0; wr_addr = 8'h00; wr_data = '0;
    rd_addr = 8'hC6; mode_in = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!prg_ready) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_in = m;
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int lows;
    // R1: defaults, clk_sel=1
    do_reset(1'b1);
    check("R1 ready", {15'd0, prg_ready}, 16'd1);
    check("R1 timer", div_timer, 16'h018);
    check("R1 vco_a", div_vco_a, 16'h088);
    check("R1 ref",   div_ref,   16'h040);
    check("R1 pll",   div_pll,   16'h200);
    check("R1 vco_b", div_vco_b, 16'h140);
    check("R1 conv",  div_conv,  16'h008);
    // R1: defaults, clk_sel=0
    do_reset(1'b0);
    check("R1 timer0", div_timer, 16'h017);
    check("R1 vco_a0", div_vco_a, 16'h085);
    check("R1 ref0",   div_ref,   16'h024);
    check("R1 pll0",   div_pll,   16'h1E0);
    check("R2 status idle", rd_data, 16'h0001);
    rd_addr = 8'hC8; #1;
    check("R2 other addr", rd_data, 16'h0000);
    rd_addr = 8'hC6;

    // Vector walk: R5, R6, R7
    for (int i = 0; i < 6; i++) begin
      wait_ready();
      put(8'hC8, VEC_DATA[i]);
      check("R3 ready low after accept", {15'd0, prg_ready}, 16'd0);
      check("R2 status busy", rd_data, 16'h0000);
      if (i == 0) check("R7 no commit on first", div_timer, 16'h017);
      if (i == 1) begin
        check("R7 timer pair", div_timer, VEC_DATA[0] & 16'h03FF);
        check("R7 vco_a pair", div_vco_a, VEC_DATA[1] & 16'h03FF);
      end
      if (i >= 2) check("R8 ref held before mode", div_ref, 16'h024);
    end
    set_mode(2'b01);
    check("R8 ref on rx",   div_ref,   VEC_DATA[2] & 16'h03FF);
    check("R8 pll on rx",   div_pll,   VEC_DATA[3] & 16'h03FF);
    check("R6 vco_b on rx", div_vco_b, VEC_DATA[4] & 16'h03FF);
    check("R5 conv on rx",  div_conv,  VEC_DATA[5] & 16'h03FF);

    // R3: busy length; word 7 wraps to timer (R5)
    wait_ready();
    put(8'hC8, 16'h0123);
    lows = 0;
    while (!prg_ready && lows < 50) begin lows++; @(negedge clk); end
    check("R3 busy length", 16'(lows), 16'd4);
    put(8'hC8, 16'h0321);
    check("R5 wrap timer", div_timer, 16'h0123);
    check("R5 wrap vco_a", div_vco_a, 16'h0321);

    // R4: discarded write; R8 idle/reserved no commit
    wait_ready();
    put(8'hC8, 16'h0111);
    put(8'hC8, 16'h0222);
    for (int k = 0; k < 3; k++) begin wait_ready(); put(8'hC8, 16'h0300 + 16'(k)); end
    set_mode(2'b00);
    check("R8 idle no commit", div_ref, VEC_DATA[2] & 16'h03FF);
    set_mode(2'b11);
    check("R8 reserved no commit", div_pll, VEC_DATA[3] & 16'h03FF);
    set_mode(2'b10);
    check("R4 discarded not staged", div_ref, 16'h0111);
    check("R4 order kept pll", div_pll, 16'h0300);
    check("R4 order kept conv", div_conv, 16'h0302);
    set_mode(2'b10);
    check("R8 same mode hold", div_vco_b, 16'h0301);

    // R9: foreign address ignored
    wait_ready();
    put(8'hC6, 16'h0155);
    check("R9 ready unaffected", {15'd0, prg_ready}, 16'd1);
    put(8'hC8, 16'h00AA);
    wait_ready();
    put(8'hC8, 16'h00BB);
    check("R9 timer", div_timer, 16'h00AA);
    check("R9 vco_a", div_vco_a, 16'h00BB);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule